// File: doc/BRIEF.md
# H-Bridge Gate Control with Fault Latch

This block turns two direction inputs, an active-high disable input and an enable input into the four switch enables of a two-leg H-bridge. Each leg has a high-side and a low-side switch. In normal drive, each direction input pulls its leg to the supply when it is high and to ground when it is low. Setting both inputs to the same level makes the load current recirculate, through the high side or through the low side. The block also drives an active-low status flag and reports sleep and the high-impedance state of each leg.

Short-circuit and over-temperature indications latch the bridge off, whatever the direction inputs command. The latch clears only on a high-to-low edge of the disable input or a low-to-high edge of the enable input. An over-temperature latch also needs the temperature to be below the recovery level. Under-voltage turns the bridge off and recovers by itself. A current-limit off request from the regulator turns the bridge off without raising the flag. All inputs pass through two-flop synchronizers. A dead-time counter keeps the two switches of a leg from ever conducting together.

Top module: `hbridge_gate_ctrl`

## Requirements
- R1: With enable high, disable low and no fault, under-voltage or current-limit request, leg g drives high-side on (hs=1, ls=0) when its direction input is 1 and low-side on (hs=0, ls=1) when it is 0. This gives forward (10), reverse (01), low recirculation (00) and high recirculation (11).
- R2: With enable high and disable high, all four switches are off, both legs report high impedance, and sf_n_o is 0.
- R3: With enable low, all four switches are off, sleep_o is 1 and sf_n_o is 1, including while a fault is latched.
- R4: A short-circuit or over-temperature indication latches all switches off and sf_n_o low. The latch persists after the indication goes away and while the direction inputs change.
- R5: A latched short-circuit fault clears on a high-to-low edge of the disable input or a low-to-high edge of the enable input. After that, drive follows the inputs again and sf_n_o returns to 1.
- R6: A latched over-temperature fault stays latched through a clearing edge while temp_ok_i is 0. It clears on such an edge when temp_ok_i is 1.
- R7: Under-voltage turns all switches off with sf_n_o low. When it goes away, the commanded drive and sf_n_o=1 return with no edge on the disable or enable inputs.
- R8: A current-limit off request turns all switches off while it is present and leaves sf_n_o at 1.
- R9: The high-side and low-side enables of one leg are never 1 together. When a leg moves between high-side on and low-side on, it stays with both switches off for exactly DEAD_CYC+1 cycles.
- R10: Reset clears any latched fault and holds all switches off with sleep_o=1 and sf_n_o=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in1_i | input | 1 | Direction of leg 1 (1 = supply) |
| in2_i | input | 1 | Direction of leg 2 (1 = supply) |
| dis_i | input | 1 | Disable, active high |
| en_i | input | 1 | Enable; low selects sleep |
| short_i | input | 1 | Short-circuit indication |
| otemp_i | input | 1 | Over-temperature indication |
| temp_ok_i | input | 1 | Temperature below recovery level |
| uv_i | input | 1 | Under-voltage indication |
| ilim_off_i | input | 1 | Current-limit off request |
| hs1_o | output | 1 | Leg 1 high-side enable |
| ls1_o | output | 1 | Leg 1 low-side enable |
| hs2_o | output | 1 | Leg 2 high-side enable |
| ls2_o | output | 1 | Leg 2 low-side enable |
| leg1_z_o | output | 1 | Leg 1 high impedance |
| leg2_z_o | output | 1 | Leg 2 high impedance |
| sleep_o | output | 1 | Sleep state |
| sf_n_o | output | 1 | Status flag, active low |

## Verification
The assertions assume DEAD_CYC is at least 1. They also assume that every input, however unsynchronized, reaches the logic only through the synchronizers, so status and drive move together with the fixed register offsets of the block. The stimulus holds each input setting long enough for synchronization and the full dead time to settle before it samples. It removes fault indications before it toggles the clearing inputs, and it changes inputs only on the falling clock edge.

// File: rtl/hbg_pkg.sv
package hbg_pkg;
  typedef enum logic [1:0] {
    LEG_OFF = 2'd0,
    LEG_HI  = 2'd1,
    LEG_LO  = 2'd2
  } leg_st_e;

  // synchronized input bit positions
  localparam int unsigned IX_ILIM  = 0;
  localparam int unsigned IX_UV    = 1;
  localparam int unsigned IX_TOK   = 2;
  localparam int unsigned IX_OTEMP = 3;
  localparam int unsigned IX_SHORT = 4;
  localparam int unsigned IX_EN    = 5;
  localparam int unsigned IX_DIS   = 6;
  localparam int unsigned IX_IN2   = 7;
  localparam int unsigned IX_IN1   = 8;
  localparam int unsigned N_IN     = 9;
endpackage

// File: rtl/hbg_sync.sv
module hbg_sync #(
  parameter int unsigned W      = 1,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] pipe_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < STAGES; s++) pipe_q[s] <= '0;
    end else begin
      pipe_q[0] <= d_i;
      for (int s = 1; s < STAGES; s++) pipe_q[s] <= pipe_q[s-1];
    end
  end

  assign q_o = pipe_q[STAGES-1];
endmodule

// File: rtl/hbg_fault_latch.sv
module hbg_fault_latch (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic dis_i,
  input  logic en_i,
  input  logic short_i,
  input  logic otemp_i,
  input  logic temp_ok_i,
  output logic fault_o
);
  logic dis_prev_q, en_prev_q, sc_q, ot_q;
  logic clr_edge;

  assign clr_edge = (dis_prev_q & ~dis_i) | (~en_prev_q & en_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dis_prev_q <= 1'b0;
      en_prev_q  <= 1'b0;
      sc_q       <= 1'b0;
      ot_q       <= 1'b0;
    end else begin
      dis_prev_q <= dis_i;
      en_prev_q  <= en_i;
      // set wins over clear
      if (short_i)       sc_q <= 1'b1;
      else if (clr_edge) sc_q <= 1'b0;
      if (otemp_i)                    ot_q <= 1'b1;
      else if (clr_edge && temp_ok_i) ot_q <= 1'b0;
    end
  end

  assign fault_o = sc_q | ot_q;
endmodule

// File: rtl/hbg_leg.sv
module hbg_leg
  import hbg_pkg::*;
#(
  parameter int unsigned DEAD_CYC = 3
) (
  input  logic    clk_i,
  input  logic    rst_ni,
  input  leg_st_e tgt_i,
  output logic    hs_o,
  output logic    ls_o,
  output logic    z_o
);
  localparam int unsigned CW = (DEAD_CYC < 1) ? 1 : $clog2(DEAD_CYC + 1);
  localparam logic [CW-1:0] DEAD_LD = CW'(DEAD_CYC);

  leg_st_e       cur_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cur_q <= LEG_OFF;
      cnt_q <= '0;
    end else if (cur_q != LEG_OFF) begin
      if (tgt_i != cur_q) begin
        cur_q <= LEG_OFF;
        cnt_q <= DEAD_LD;
      end
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end else begin
      cur_q <= tgt_i;
    end
  end

  assign hs_o = (cur_q == LEG_HI);
  assign ls_o = (cur_q == LEG_LO);
  assign z_o  = (cur_q == LEG_OFF);
endmodule

// File: rtl/hbridge_gate_ctrl.sv
module hbridge_gate_ctrl
  import hbg_pkg::*;
#(
  parameter int unsigned DEAD_CYC = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic in1_i,
  input  logic in2_i,
  input  logic dis_i,
  input  logic en_i,
  input  logic short_i,
  input  logic otemp_i,
  input  logic temp_ok_i,
  input  logic uv_i,
  input  logic ilim_off_i,
  output logic hs1_o,
  output logic ls1_o,
  output logic hs2_o,
  output logic ls2_o,
  output logic leg1_z_o,
  output logic leg2_z_o,
  output logic sleep_o,
  output logic sf_n_o
);
  localparam int unsigned N_LEG = 2;

  logic [N_IN-1:0]  raw, syn;
  logic             fault;
  logic             drive_ok;
  logic [N_LEG-1:0] dir, hs, ls, lz;

  assign raw = {in1_i, in2_i, dis_i, en_i, short_i, otemp_i, temp_ok_i, uv_i, ilim_off_i};

  hbg_sync #(.W(N_IN), .STAGES(2)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (raw),
    .q_o   (syn)
  );

  hbg_fault_latch u_flt (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .dis_i    (syn[IX_DIS]),
    .en_i     (syn[IX_EN]),
    .short_i  (syn[IX_SHORT]),
    .otemp_i  (syn[IX_OTEMP]),
    .temp_ok_i(syn[IX_TOK]),
    .fault_o  (fault)
  );

  assign drive_ok = syn[IX_EN] & ~syn[IX_DIS] & ~syn[IX_UV] & ~fault & ~syn[IX_ILIM];
  assign dir      = {syn[IX_IN2], syn[IX_IN1]};

  for (genvar g = 0; g < N_LEG; g++) begin : g_leg
    leg_st_e tgt;
    assign tgt = !drive_ok ? LEG_OFF : (dir[g] ? LEG_HI : LEG_LO);
    hbg_leg #(.DEAD_CYC(DEAD_CYC)) u_leg (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .tgt_i (tgt),
      .hs_o  (hs[g]),
      .ls_o  (ls[g]),
      .z_o   (lz[g])
    );
  end

  assign hs1_o    = hs[0];
  assign ls1_o    = ls[0];
  assign hs2_o    = hs[1];
  assign ls2_o    = ls[1];
  assign leg1_z_o = lz[0];
  assign leg2_z_o = lz[1];
  assign sleep_o  = ~syn[IX_EN];
  // sleep masks the flag; ilim does not set it
  assign sf_n_o   = ~syn[IX_EN] | ~(syn[IX_DIS] | syn[IX_UV] | fault);
endmodule

// File: rtl/hbg_checker.sv
module hbg_checker (
  input logic clk_i,
  input logic rst_ni,
  input logic hs1_o,
  input logic ls1_o,
  input logic hs2_o,
  input logic ls2_o,
  input logic sleep_o,
  input logic sf_n_o
);
  assert_no_shoot1_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(hs1_o && ls1_o));
  assert_no_shoot2_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(hs2_o && ls2_o));
  assert_dead_hl1_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(hs1_o) |=> !ls1_o);
  assert_dead_lh1_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ls1_o) |=> !hs1_o);
  assert_dead_hl2_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(hs2_o) |=> !ls2_o);
  assert_sleep_flag_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sleep_o |-> sf_n_o);
  assert_sleep_off_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sleep_o |=> !(hs1_o || ls1_o || hs2_o || ls2_o));
  assert_flag_off_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sf_n_o |=> !(hs1_o || ls1_o || hs2_o || ls2_o));
endmodule

bind hbridge_gate_ctrl hbg_checker u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .hs1_o  (hs1_o),
  .ls1_o  (ls1_o),
  .hs2_o  (hs2_o),
  .ls2_o  (ls2_o),
  .sleep_o(sleep_o),
  .sf_n_o (sf_n_o)
);

// File: tb/hbridge_gate_ctrl_tb.sv
module hbridge_gate_ctrl_tb;
  localparam int unsigned DEAD = 3;
  localparam int unsigned SETTLE = 12;
  localparam int unsigned NVEC = 9;
  // {en,dis,in1,in2,uv,ilim} , {hs1,ls1,hs2,ls2,sf_n,sleep}
  localparam logic [11:0] VEC [NVEC] = '{
    {6'b101000, 6'b100110},  // R1 forward
    {6'b100100, 6'b011010},  // R1 reverse
    {6'b100000, 6'b010110},  // R1 low recirculation
    {6'b101100, 6'b101010},  // R1 high recirculation
    {6'b111000, 6'b000000},  // R2 disabled
    {6'b001000, 6'b000011},  // R3 sleep
    {6'b101010, 6'b000000},  // R7 under-voltage
    {6'b100100, 6'b011010},  // R7 auto recovery
    {6'b101001, 6'b000010}   // R8 current-limit off
  };
  localparam string VREQ [NVEC] = '{"R1","R1","R1","R1","R2","R3","R7","R7","R8"};

  logic clk = 1'b0, rst_ni = 1'b0;
  logic in1 = 0, in2 = 0, dis = 0, en = 0, sc = 0, ot = 0, tok = 1, uv = 0, ilim = 0;
  logic hs1, ls1, hs2, ls2, z1, z2, slp, sf_n;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  hbridge_gate_ctrl #(.DEAD_CYC(DEAD)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .in1_i(in1), .in2_i(in2), .dis_i(dis), .en_i(en),
    .short_i(sc), .otemp_i(ot), .temp_ok_i(tok), .uv_i(uv), .ilim_off_i(ilim),
    .hs1_o(hs1), .ls1_o(ls1), .hs2_o(hs2), .ls2_o(ls2), .leg1_z_o(z1), .leg2_z_o(z2),
    .sleep_o(slp), .sf_n_o(sf_n)
  );

  function automatic logic [5:0] obs();
    return {hs1, ls1, hs2, ls2, sf_n, slp};
  endfunction

  task automatic chk(input string req, input logic [5:0] act, input logic [5:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %b expected %b", req, act, exp);
    end
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic toggle_dis();
    dis = 1; settle(SETTLE);
    dis = 0; settle(SETTLE);
  endtask

  // R9 overlap monitor
  always @(negedge clk) begin
    if (rst_ni && ((hs1 && ls1) || (hs2 && ls2))) begin
      n_bad++;
      $display("FAIL R9: overlap hs1=%b ls1=%b hs2=%b ls2=%b expected no overlap", hs1, ls1, hs2, ls2);
    end
  end

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      n_chk++;
      $display("FAIL watchdog: got timeout expected completion");
      finish_run();
    end
  end

  initial begin
    settle(3);
    chk("R10 reset", obs(), 6'b000011);
    chk("R10 reset z", {z1, z2}, 2'b11);
    rst_ni = 1;
    settle(SETTLE);
    chk("R10 after reset, en low", obs(), 6'b000011);

    for (int i = 0; i < NVEC; i++) begin
      {en, dis, in1, in2, uv, ilim} = VEC[i][11:6];
      settle(SETTLE);
      chk(VREQ[i], obs(), VEC[i][5:0]);
    end

    // R9 dead time: forward -> reverse on leg 1
    {en, dis, in1, in2, uv, ilim} = 6'b101000;
    settle(SETTLE);
    in1 = 0; in2 = 1;
    begin
      int zc = 0;
      for (int k = 0; k < 20; k++) begin
        @(negedge clk);
        if (z1) zc++;
      end
      chk("R9 dead cycles", 6'(zc), 6'(DEAD + 1));
    end
    chk("R9 after dead time", obs(), 6'b011010);

    // R4 short latch
    in1 = 1; in2 = 0; settle(SETTLE);
    sc = 1; settle(8); sc = 0; settle(SETTLE);
    chk("R4 short latched", obs(), 6'b000000);
    in1 = 0; in2 = 1; settle(SETTLE);
    chk("R4 latch ignores direction", obs(), 6'b000000);
    // R5 clear via disable falling edge
    toggle_dis();
    chk("R5 clear on disable fall", obs(), 6'b011010);
    // R5 clear via enable rising edge
    sc = 1; settle(8); sc = 0; settle(SETTLE);
    chk("R4 short latched again", obs(), 6'b000000);
    en = 0; settle(SETTLE);
    chk("R3 sleep masks latched flag", obs(), 6'b000011);
    en = 1; settle(SETTLE);
    chk("R5 clear on enable rise", obs(), 6'b011010);

    // R6 over-temperature with hysteresis
    tok = 0; ot = 1; settle(8); ot = 0; settle(SETTLE);
    chk("R6 otemp latched", obs(), 6'b000000);
    toggle_dis();
    chk("R6 no release while hot", obs(), 6'b000000);
    tok = 1; toggle_dis();
    chk("R6 release when cool", obs(), 6'b011010);

    // R10 reset clears latch
    sc = 1; settle(8); sc = 0; settle(SETTLE);
    chk("R10 latched before reset", obs(), 6'b000000);
    rst_ni = 0; settle(2);
    chk("R10 in reset", obs(), 6'b000011);
    rst_ni = 1; settle(SETTLE);
    chk("R10 fault cleared by reset", obs(), 6'b011010);

    done = 1;
    finish_run();
  end
endmodule